// File: doc/BRIEF.md
# Power Domain Rule Monitor

This block watches the power-management control pins of a group of power domains from the always-on clock. It raises a sticky error flag when a low-power rule is broken. The rules are: a register access aimed at an unpowered domain, a clock or reset enable active into an unpowered domain, several rails switching in one cycle, isolation requested while it is already in force, save and restore issued together, and a power-state move that the legal-move table does not allow. Moves into a forbidden state and moves out of one are reported as separate classes.

Each error class has a sticky flag and a saturating counter. Both stay until `clr_i` is pulsed. The block also keeps two coverage bitmaps: one for the power states reached since reset and one for the state-to-state moves taken. A registered copy of the previous state and of the previous rail vector gives the reference for all the state and rail comparisons. Every pin is plain control or status. There is no data stream, so the block has no valid/ready handshake and applies no back-pressure.

Error class bit positions in `err_flag_o`, and counter slices `err_cnt_o[k*CNT_W +: CNT_W]`:
0 = access to off domain, 1 = gated enable while off, 2 = multi-rail change, 3 = redundant isolation, 4 = save/restore overlap, 5 = disallowed move, 6 = move into forbidden state, 7 = move out of forbidden state.

Top module: `pdm_rule_monitor`

## Requirements
- R1: A cycle with `acc_vld_i` high and `pwr_on_i[acc_dom_i]` low sets flag bit 0 at the next clock edge. An access to a powered domain has no effect.
- R2: A cycle where any domain has `pwr_on_i` low and `clk_en_i` or `rst_en_i` high for that domain sets flag bit 1. Enables into powered domains have no effect.
- R3: If more than one bit of `pwr_on_i` differs from its value in the previous cycle, flag bit 2 is set. A single rail change is not an error.
- R4: Isolation for a domain becomes active on `iso_set_i` and ends on `iso_rel_i`. An `iso_set_i` pulse while that domain's isolation is already active sets flag bit 3. A set after a release is not an error.
- R5: `save_i` and `restore_i` both high for the same domain in one cycle sets flag bit 4. Save and restore on different domains are not an error.
- R6: A change of `pstate_i` between two allowed states sets flag bit 5 when table bit `LEGAL_MOVES[src*N_PST+dst]` is 0. The default table allows only 0<->1 and 1<->2, and a constant state is never checked.
- R7: A change into a state marked in `BAD_STATES` (default: state 3) sets flag bit 6 only. A change from such a state into an allowed one sets flag bit 7 only.
- R8: `visit_o[s]` is set once state `s` has been sampled after reset. `tcov_o[src*N_PST+dst]` is set once that move has been seen.
- R9: Flags and counters hold until `clr_i`. A `clr_i` cycle zeroes them, unless the same cycle has a new violation, which then leaves that flag at 1 and its counter at 1.
- R10: Each counter counts cycles with a violation of its class and saturates at 2^CNT_W-1 (15 by default).
- R11: While `rst_ni` is low, all flags, counters and coverage bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear pulse for flags and counters |
| pstate_i | input | ST_W | Current power state code |
| pwr_on_i | input | N_DOM | Rail on, per domain |
| iso_set_i | input | N_DOM | Isolation activate pulse, per domain |
| iso_rel_i | input | N_DOM | Isolation release pulse, per domain |
| save_i | input | N_DOM | State save, per domain |
| restore_i | input | N_DOM | State restore, per domain |
| clk_en_i | input | N_DOM | Gated clock enable, per domain |
| rst_en_i | input | N_DOM | Gated reset enable, per domain |
| acc_vld_i | input | 1 | Register access strobe |
| acc_dom_i | input | DOM_W | Target domain of the access |
| err_flag_o | output | 8 | Sticky flag per error class |
| err_cnt_o | output | 8*CNT_W | Saturating counter per error class |
| visit_o | output | N_PST | States reached since reset |
| tcov_o | output | N_PST*N_PST | Moves taken since reset |

## Verification
Every result is due at the first clock edge after the violating sample. Rail and state checks compare against the copy registered one edge earlier, and the isolation check uses state set by earlier pulses. The bench drives each stimulus on a falling edge, holds it across exactly one rising edge, and reads flags, counters and bitmaps on the next falling edge. Checks that something "has no effect" read the flag vector at that same point. Stickiness and saturation are read after many idle or repeated cycles.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int N_CLS    = 8;
  localparam int CLS_ACC  = 0;
  localparam int CLS_GATE = 1;
  localparam int CLS_RAIL = 2;
  localparam int CLS_ISO  = 3;
  localparam int CLS_OVL  = 4;
  localparam int CLS_MOVE = 5;
  localparam int CLS_INTO = 6;
  localparam int CLS_FROM = 7;
endpackage

// File: rtl/pdm_dom_rules.sv
module pdm_dom_rules #(
  parameter int N_DOM = 4,
  parameter int DOM_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DOM-1:0] pwr_on_i,
  input  logic [N_DOM-1:0] prev_pwr_i,
  input  logic             prev_vld_i,
  input  logic [N_DOM-1:0] iso_set_i,
  input  logic [N_DOM-1:0] iso_rel_i,
  input  logic [N_DOM-1:0] save_i,
  input  logic [N_DOM-1:0] restore_i,
  input  logic [N_DOM-1:0] clk_en_i,
  input  logic [N_DOM-1:0] rst_en_i,
  input  logic             acc_vld_i,
  input  logic [DOM_W-1:0] acc_dom_i,
  output logic             hit_acc_o,
  output logic             hit_gate_o,
  output logic             hit_rail_o,
  output logic             hit_iso_o,
  output logic             hit_ovl_o
);
  logic [N_DOM-1:0] iso_q;
  logic [N_DOM-1:0] acc_bad, gate_bad, iso_bad, ovl_bad;
  logic [N_DOM-1:0] rail_diff;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    // isolation tracker: set pulse wins over a same-cycle release
    always_ff @(posedge clk_i) begin
      if (!rst_ni)           iso_q[d] <= 1'b0;
      else if (iso_set_i[d]) iso_q[d] <= 1'b1;
      else if (iso_rel_i[d]) iso_q[d] <= 1'b0;
    end
    assign acc_bad[d]  = acc_vld_i && (acc_dom_i == DOM_W'(d)) && !pwr_on_i[d];
    assign gate_bad[d] = !pwr_on_i[d] && (clk_en_i[d] || rst_en_i[d]);
    assign iso_bad[d]  = iso_set_i[d] && iso_q[d];
    assign ovl_bad[d]  = save_i[d] && restore_i[d];
  end

  assign rail_diff  = pwr_on_i ^ prev_pwr_i;
  assign hit_acc_o  = |acc_bad;
  assign hit_gate_o = |gate_bad;
  assign hit_iso_o  = |iso_bad;
  assign hit_ovl_o  = |ovl_bad;
  assign hit_rail_o = prev_vld_i && ($countones(rail_diff) > 1);
endmodule

// File: rtl/pdm_state_track.sv
module pdm_state_track #(
  parameter int                     N_PST       = 4,
  parameter int                     ST_W        = 2,
  parameter logic [N_PST*N_PST-1:0] LEGAL_MOVES = '0,
  parameter logic [N_PST-1:0]       BAD_STATES  = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ST_W-1:0]          cur_i,
  input  logic [ST_W-1:0]          prev_i,
  input  logic                     prev_vld_i,
  output logic                     hit_move_o,
  output logic                     hit_into_o,
  output logic                     hit_from_o,
  output logic [N_PST-1:0]         visit_o,
  output logic [N_PST*N_PST-1:0]   tcov_o
);
  localparam int TBL   = N_PST * N_PST;
  localparam int TIX_W = (TBL > 1) ? $clog2(TBL) : 1;

  logic             moved, cur_bad, prev_bad;
  logic [TIX_W-1:0] tix;

  always_comb begin
    tix        = TIX_W'(prev_i) * TIX_W'(N_PST) + TIX_W'(cur_i);
    moved      = prev_vld_i && (cur_i != prev_i);
    cur_bad    = BAD_STATES[cur_i];
    prev_bad   = BAD_STATES[prev_i];
    hit_into_o = moved && cur_bad;
    hit_from_o = moved && !cur_bad && prev_bad;
    hit_move_o = moved && !cur_bad && !prev_bad && !LEGAL_MOVES[tix];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      visit_o <= '0;
      tcov_o  <= '0;
    end else begin
      visit_o[cur_i] <= 1'b1;
      if (moved) tcov_o[tix] <= 1'b1;
    end
  end
endmodule

// File: rtl/pdm_err_bank.sv
module pdm_err_bank #(
  parameter int N_CLS = 8,
  parameter int CNT_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic [N_CLS-1:0]       hit_i,
  output logic [N_CLS-1:0]       flag_o,
  output logic [N_CLS*CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar k = 0; k < N_CLS; k++) begin : g_cls
    logic [CNT_W-1:0] cnt_q, base;
    assign base = clr_i ? '0 : cnt_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        flag_o[k] <= 1'b0;
        cnt_q     <= '0;
      end else begin
        flag_o[k] <= hit_i[k] | (flag_o[k] & ~clr_i);
        if (hit_i[k]) cnt_q <= (base == CMAX) ? base : base + 1'b1;
        else          cnt_q <= base;
      end
    end
    assign cnt_o[k*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/pdm_rule_monitor.sv
module pdm_rule_monitor
  import pdm_pkg::*;
#(
  parameter int                     N_DOM       = 4,
  parameter int                     N_PST       = 4,
  parameter int                     CNT_W       = 4,
  parameter logic [N_PST*N_PST-1:0] LEGAL_MOVES = 16'h0252,
  parameter logic [N_PST-1:0]       BAD_STATES  = 4'h8,
  localparam int                    ST_W        = (N_PST > 1) ? $clog2(N_PST) : 1,
  localparam int                    DOM_W       = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic [ST_W-1:0]          pstate_i,
  input  logic [N_DOM-1:0]         pwr_on_i,
  input  logic [N_DOM-1:0]         iso_set_i,
  input  logic [N_DOM-1:0]         iso_rel_i,
  input  logic [N_DOM-1:0]         save_i,
  input  logic [N_DOM-1:0]         restore_i,
  input  logic [N_DOM-1:0]         clk_en_i,
  input  logic [N_DOM-1:0]         rst_en_i,
  input  logic                     acc_vld_i,
  input  logic [DOM_W-1:0]         acc_dom_i,
  output logic [N_CLS-1:0]         err_flag_o,
  output logic [N_CLS*CNT_W-1:0]   err_cnt_o,
  output logic [N_PST-1:0]         visit_o,
  output logic [N_PST*N_PST-1:0]   tcov_o
);
  logic             prev_vld_q;
  logic [N_DOM-1:0] prev_pwr_q;
  logic [ST_W-1:0]  prev_st_q;
  logic [N_CLS-1:0] hit;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_vld_q <= 1'b0;
      prev_pwr_q <= '0;
      prev_st_q  <= '0;
    end else begin
      prev_vld_q <= 1'b1;
      prev_pwr_q <= pwr_on_i;
      prev_st_q  <= pstate_i;
    end
  end

  pdm_dom_rules #(.N_DOM(N_DOM), .DOM_W(DOM_W)) u_dom (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pwr_on_i(pwr_on_i), .prev_pwr_i(prev_pwr_q), .prev_vld_i(prev_vld_q),
    .iso_set_i(iso_set_i), .iso_rel_i(iso_rel_i),
    .save_i(save_i), .restore_i(restore_i),
    .clk_en_i(clk_en_i), .rst_en_i(rst_en_i),
    .acc_vld_i(acc_vld_i), .acc_dom_i(acc_dom_i),
    .hit_acc_o(hit[CLS_ACC]), .hit_gate_o(hit[CLS_GATE]),
    .hit_rail_o(hit[CLS_RAIL]), .hit_iso_o(hit[CLS_ISO]),
    .hit_ovl_o(hit[CLS_OVL])
  );

  pdm_state_track #(
    .N_PST(N_PST), .ST_W(ST_W),
    .LEGAL_MOVES(LEGAL_MOVES), .BAD_STATES(BAD_STATES)
  ) u_st (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cur_i(pstate_i), .prev_i(prev_st_q), .prev_vld_i(prev_vld_q),
    .hit_move_o(hit[CLS_MOVE]), .hit_into_o(hit[CLS_INTO]),
    .hit_from_o(hit[CLS_FROM]),
    .visit_o(visit_o), .tcov_o(tcov_o)
  );

  pdm_err_bank #(.N_CLS(N_CLS), .CNT_W(CNT_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .hit_i(hit), .flag_o(err_flag_o), .cnt_o(err_cnt_o)
  );
endmodule

// File: rtl/pdm_rule_monitor_chk.sv
module pdm_rule_monitor_chk #(
  parameter int               N_DOM      = 4,
  parameter int               N_PST      = 4,
  parameter int               CNT_W      = 4,
  parameter int               ST_W       = 2,
  parameter int               DOM_W      = 2,
  parameter int               N_CLS      = 8,
  parameter logic [N_PST-1:0] BAD_STATES = 4'h8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   clr_i,
  input logic [ST_W-1:0]        pstate_i,
  input logic [N_DOM-1:0]       pwr_on_i,
  input logic [N_DOM-1:0]       save_i,
  input logic [N_DOM-1:0]       restore_i,
  input logic [N_DOM-1:0]       clk_en_i,
  input logic [N_DOM-1:0]       rst_en_i,
  input logic                   acc_vld_i,
  input logic [DOM_W-1:0]       acc_dom_i,
  input logic [N_CLS-1:0]       err_flag_o,
  input logic [N_CLS*CNT_W-1:0] err_cnt_o,
  input logic [N_PST-1:0]       visit_o
);
  logic             seen_q;
  logic [N_DOM-1:0] pw_q;
  logic [ST_W-1:0]  st_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      pw_q   <= '0;
      st_q   <= '0;
    end else begin
      seen_q <= 1'b1;
      pw_q   <= pwr_on_i;
      st_q   <= pstate_i;
    end
  end

  assert_off_access_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && !pwr_on_i[acc_dom_i]) |=> err_flag_o[0]);

  assert_gated_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~pwr_on_i & (clk_en_i | rst_en_i))) |=> err_flag_o[1]);

  assert_multi_rail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ($countones(pwr_on_i ^ pw_q) > 1)) |=> err_flag_o[2]);

  assert_save_restore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(save_i & restore_i)) |=> err_flag_o[4]);

  assert_into_bad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && (pstate_i != st_q) && BAD_STATES[pstate_i]) |=> (err_flag_o[6] && !err_flag_o[5]) || $past(err_flag_o[5]));

  assert_visit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> visit_o[$past(pstate_i)]);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((err_flag_o & $past(err_flag_o)) == $past(err_flag_o)));

  for (genvar k = 0; k < N_CLS; k++) begin : g_cnt
    assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (err_cnt_o[k*CNT_W +: CNT_W] >= $past(err_cnt_o[k*CNT_W +: CNT_W])));
  end
endmodule

bind pdm_rule_monitor pdm_rule_monitor_chk #(
  .N_DOM(N_DOM), .N_PST(N_PST), .CNT_W(CNT_W), .ST_W(ST_W),
  .DOM_W(DOM_W), .N_CLS(pdm_pkg::N_CLS), .BAD_STATES(BAD_STATES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .pstate_i(pstate_i),
  .pwr_on_i(pwr_on_i), .save_i(save_i), .restore_i(restore_i),
  .clk_en_i(clk_en_i), .rst_en_i(rst_en_i), .acc_vld_i(acc_vld_i),
  .acc_dom_i(acc_dom_i), .err_flag_o(err_flag_o), .err_cnt_o(err_cnt_o),
  .visit_o(visit_o)
);

// File: tb/tb_pdm_rule_monitor.sv
module tb_pdm_rule_monitor;
  logic        clk = 1'b0;
  logic        rst_n, clr;
  logic [1:0]  pstate;
  logic [3:0]  pwr_on, iso_set, iso_rel, save, restore, clk_en, rst_en;
  logic        acc_vld;
  logic [1:0]  acc_dom;
  logic [7:0]  eflag;
  logic [31:0] ecnt;
  logic [3:0]  visit;
  logic [15:0] tcov;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pdm_rule_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .pstate_i(pstate),
    .pwr_on_i(pwr_on), .iso_set_i(iso_set), .iso_rel_i(iso_rel),
    .save_i(save), .restore_i(restore), .clk_en_i(clk_en), .rst_en_i(rst_en),
    .acc_vld_i(acc_vld), .acc_dom_i(acc_dom),
    .err_flag_o(eflag), .err_cnt_o(ecnt), .visit_o(visit), .tcov_o(tcov)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cnt(input int k);
    return ecnt[k*4 +: 4];
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 flags", eflag, 0);
    chk("R11 counters", ecnt, 0);
    chk("R11 coverage", {visit, tcov}, 0);
    rst_n = 1'b1; tick();
    chk("R8 first visit", visit, 4'b0100);
    chk("R8 no move yet", tcov, 0);
  endtask

  task automatic t_access_gate();
    acc_vld = 1'b1; acc_dom = 2'd0; tick(); acc_vld = 1'b0;
    chk("R1 access to powered domain", eflag, 0);
    pwr_on = 4'b1101; tick();
    chk("R3 single rail change", eflag, 0);
    acc_vld = 1'b1; acc_dom = 2'd1; tick(); acc_vld = 1'b0;
    chk("R1 access to off domain", eflag, 8'h01);
    chk("R1 counter", cnt(0), 1);
    clk_en = 4'b0001; tick(); clk_en = 4'b0000;
    chk("R2 enable into powered domain", eflag[1], 0);
    chk("R9 flag held", eflag[0], 1);
    rst_en = 4'b0010; tick(); rst_en = 4'b0000;
    chk("R2 reset enable while off", eflag, 8'h03);
    pwr_on = 4'hF; pulse_clr();
    chk("R9 clear flags", eflag, 0);
    chk("R9 clear counters", ecnt, 0);
  endtask

  task automatic t_rail();
    pwr_on = 4'h3; tick();
    chk("R3 two rails in one cycle", eflag, 8'h04);
    pwr_on = 4'hF; tick();
    chk("R3 counter", cnt(2), 2);
    pulse_clr();
  endtask

  task automatic t_iso();
    iso_set = 4'b0100; tick(); iso_set = 4'b0;
    chk("R4 first activation", eflag, 0);
    iso_set = 4'b0100; tick(); iso_set = 4'b0;
    chk("R4 redundant activation", eflag, 8'h08);
    iso_rel = 4'b0100; tick(); iso_rel = 4'b0;
    iso_set = 4'b0100; tick(); iso_set = 4'b0;
    chk("R4 set after release", cnt(3), 1);
    iso_rel = 4'b0100; tick(); iso_rel = 4'b0;
    pulse_clr();
  endtask

  task automatic t_ovl();
    save = 4'b1000; restore = 4'b1000; tick(); save = 4'b0; restore = 4'b0;
    chk("R5 save and restore together", eflag, 8'h10);
    pulse_clr();
    save = 4'b1000; restore = 4'b0001; tick(); save = 4'b0; restore = 4'b0;
    chk("R5 different domains", eflag, 0);
  endtask

  task automatic t_moves();
    pstate = 2'd1; tick();
    chk("R6 legal 2->1", eflag, 0);
    pstate = 2'd0; tick();
    chk("R6 legal 1->0", eflag, 0);
    pstate = 2'd2; tick();
    chk("R6 disallowed 0->2", eflag, 8'h20);
    pulse_clr();
    pstate = 2'd3; tick();
    chk("R7 into forbidden", eflag, 8'h40);
    pulse_clr();
    pstate = 2'd2; tick();
    chk("R7 out of forbidden", eflag, 8'h80);
    chk("R8 visited", visit, 4'hF);
    chk("R8 moves taken", tcov, 16'h4A14);
    pulse_clr();
  endtask

  task automatic t_saturate();
    iso_set = 4'b0001;
    repeat (20) tick();
    chk("R10 saturation", cnt(3), 15);
    chk("R10 flag", eflag, 8'h08);
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R9 violation during clear flag", eflag, 8'h08);
    chk("R9 violation during clear count", cnt(3), 1);
    iso_set = 4'b0; iso_rel = 4'b0001; tick(); iso_rel = 4'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; pstate = 2'd2; pwr_on = 4'hF;
    iso_set = 0; iso_rel = 0; save = 0; restore = 0;
    clk_en = 0; rst_en = 0; acc_vld = 1'b0; acc_dom = 0;
    repeat (3) tick();
    t_reset();
    t_access_gate();
    t_rail();
    t_iso();
    t_ovl();
    t_moves();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule